// File: doc/BRIEF.md
# Multi-function I/O chip configuration port

This block is the configuration front end of a legacy multi-function I/O chip. The host reaches it through two byte-wide addresses. Address bit 0 low selects the index register, which names one of the internal configuration registers. Address bit 0 high selects the data register, which reads or writes the register that the index names. Three 8-bit registers sit behind the data register: a function-enable register (index 0), a function-address register (index 1) and a power/test register (index 2).

After reset, the three registers load a preset chosen by a 5-bit strap input. The block then turns the register contents into resource assignments for the on-chip peripherals: a parallel port, two serial ports, a floppy controller and an IDE controller. For each one it gives an enable flag, an I/O base address and an IRQ number. These outputs are registered. A one-cycle pulse marks every cycle in which they may have changed, so the peripheral logic can reconfigure itself.

The index port also carries a chip identification handshake. The first two index reads after reset return an ID byte and then a zero byte, before the port starts echoing the index.

Top module: `sio_cfg_port`

## Requirements
- R1: `bus_a0` = 0 addresses the index port and `bus_a0` = 1 addresses the data port. A read strobe in one cycle gives `rdata_vld` high with the read byte on `rdata` in the next cycle, and `rdata_vld` stays low in cycles that follow no read strobe.
- R2: After reset, the first index-port read returns 0x88 and the second returns 0x00. Every later index-port read returns the selected index.
- R3: An index-port write stores the full written byte as the selected index and ends the identification handshake, so the next index read returns that byte.
- R4: A data write with index 0, 1 or 2 replaces the enable, address or power/test register respectively. A data write with any other index leaves all three registers unchanged, and a data read with any other index returns 0x00.
- R5: Reset sets the selected index to 0 and loads the three registers from a 32-entry preset addressed by `strap`. For example, strap 1 gives enable 0x4F, address 0x11 and power/test 0x00, and strap 31 gives 0x00, 0x10 and 0x02.
- R6: `cfg_changed` is high for exactly the one cycle after each register update, including the preset load. The decoded outputs take their new values in that cycle and change at no other time.
- R7: The parallel port is enabled by enable bit 0. Address bits 1:0 select the base: code 0 gives 0x378, code 1 gives 0x3BC, code 2 gives 0x278 and code 3 gives 0. The IRQ is 7 for code 1, 5 for code 2 and 0 for code 3. For code 0 the IRQ is 7 when power/test bit 3 is set and 5 when it is clear.
- R8: Serial port 0 is enabled by enable bit 1 and uses the select code in address bits 3:2. Serial port 1 is enabled by enable bit 2 and uses address bits 5:4. Code 0 gives base 0x3F8 and code 1 gives 0x2F8. Code 2 takes its base from 0x3E8/0x338/0x2E8/0x220 and code 3 from 0x2E8/0x238/0x2E0/0x228, where address bits 7:6 pick the entry in each list. The IRQ is 3 for an odd code and 4 for an even code.
- R9: The floppy controller is enabled by enable bit 3. Its base is 0x370 when enable bit 5 is set and 0x3F0 when it is clear, and its IRQ is 6.
- R10: The IDE controller is enabled by enable bit 6. Its base is 0x170 when enable bit 7 is set and 0x1F0 when it is clear, its alternate base is the base plus 0x206, and its IRQ is 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap | input | 5 | Preset selector sampled on the first cycle after reset |
| bus_a0 | input | 1 | Port select: 0 index, 1 data |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte |
| rdata_vld | output | 1 | Read byte valid |
| cfg_changed | output | 1 | One-cycle pulse: decoded outputs refreshed |
| par_en | output | 1 | Parallel port enable |
| par_base | output | 16 | Parallel port I/O base |
| par_irq | output | 4 | Parallel port IRQ |
| uart_en | output | 2 | Serial port enables, bit n for port n |
| uart_base | output | 32 | Serial port bases, 16 bits per port, port 0 lowest |
| uart_irq | output | 8 | Serial port IRQs, 4 bits per port, port 0 lowest |
| fdc_en | output | 1 | Floppy controller enable |
| fdc_base | output | 16 | Floppy controller I/O base |
| fdc_irq | output | 4 | Floppy controller IRQ |
| ide_en | output | 1 | IDE controller enable |
| ide_base | output | 16 | IDE primary I/O base |
| ide_alt_base | output | 16 | IDE alternate I/O base |
| ide_irq | output | 4 | IDE controller IRQ |

## Verification
A wrong handshake step shows up on the first index read after reset or after an index write. The port then returns an ID or zero byte where it should echo the index, or the reverse, and this appears in the cycle after the read strobe. A corrupted register or selected index shows up in the next data read. It also shows in the resource outputs one cycle after the update that should have set them, because each such update is followed by a `cfg_changed` pulse. Outputs that move without the pulse, or a pulse with no preceding update, are seen in the cycle where they occur.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam int REG_W   = 8;
  localparam int NUM_REG = 3;
  localparam int STRAP_W = 5;
  localparam int IO_W    = 16;
  localparam int IRQ_W   = 4;
  localparam int NUM_UART = 2;

  typedef enum logic [1:0] {
    HS_ID   = 2'd0,
    HS_ZERO = 2'd1,
    HS_IDX  = 2'd2
  } hs_step_e;

  typedef struct packed {
    logic [7:0] pwr;
    logic [7:0] addr;
    logic [7:0] en;
  } cfg_regs_t;

  // address-register preset, entry 31 in the top byte
  localparam logic [255:0] ADDR_PRESET =
    256'h1010_3824_3911_1110_2439_1110_0001_0100_2439_1110_0808_0901_0100_3824_3911_1110;

  function automatic logic [7:0] preset_en(input logic [STRAP_W-1:0] s);
    logic [7:0] v;
    if (s <= 5'd5)       v = 8'h4F;
    else if (s <= 5'd11) v = 8'h4B;
    else if (s <= 5'd15) v = 8'h0F;
    else if (s <= 5'd19) v = 8'h49;
    else if (s <= 5'd23) v = 8'h07;
    else if (s <= 5'd29) v = 8'h47;
    else if (s == 5'd30) v = 8'h08;
    else                 v = 8'h00;
    return v;
  endfunction

  function automatic logic [7:0] preset_addr(input logic [STRAP_W-1:0] s);
    return ADDR_PRESET[8*s +: 8];
  endfunction

  function automatic logic [7:0] preset_pwr(input logic [STRAP_W-1:0] s);
    return (s == 5'd31) ? 8'h02 : 8'h00;
  endfunction

endpackage

// File: rtl/sio_cfg_bus.sv
module sio_cfg_bus
  import sio_cfg_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int SW = STRAP_W,
  parameter int NR = NUM_REG,
  parameter logic [RW-1:0] ID_BYTE = 8'h88
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] strap,
  input  logic          bus_a0,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [RW-1:0] wdata,
  output logic [RW-1:0] rdata,
  output logic          rdata_vld,
  output cfg_regs_t     regs,
  output logic          upd,
  output logic [RW-1:0] sel_idx
);

  logic          load_q;
  cfg_regs_t     regs_q, regs_d;
  logic [RW-1:0] idx_q, idx_d;
  hs_step_e      step_q, step_d;
  logic          upd_q, upd_d;
  logic [RW-1:0] rdata_q, rdata_d;
  logic          vld_q;
  logic          idx_ok;
  logic [RW-1:0] reg_rd;

  assign idx_ok = (idx_q < RW'(NR));

  always_comb begin
    unique case (idx_q[1:0])
      2'd0:    reg_rd = regs_q.en;
      2'd1:    reg_rd = regs_q.addr;
      default: reg_rd = regs_q.pwr;
    endcase
  end

  always_comb begin
    regs_d  = regs_q;
    idx_d   = idx_q;
    step_d  = step_q;
    upd_d   = 1'b0;
    rdata_d = rdata_q;
    if (rd_en) begin
      if (!bus_a0) begin
        unique case (step_q)
          HS_ID: begin
            rdata_d = ID_BYTE;
            step_d  = HS_ZERO;
          end
          HS_ZERO: begin
            rdata_d = '0;
            step_d  = HS_IDX;
          end
          default: rdata_d = idx_q;
        endcase
      end else begin
        rdata_d = idx_ok ? reg_rd : '0;
      end
    end
    if (wr_en && !bus_a0) begin
      idx_d  = wdata;
      step_d = HS_IDX;
    end
    if (load_q) begin
      regs_d.en   = preset_en(strap);
      regs_d.addr = preset_addr(strap);
      regs_d.pwr  = preset_pwr(strap);
      upd_d       = 1'b1;
    end else if (wr_en && bus_a0 && idx_ok) begin
      unique case (idx_q[1:0])
        2'd0:    regs_d.en   = wdata;
        2'd1:    regs_d.addr = wdata;
        default: regs_d.pwr  = wdata;
      endcase
      upd_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q  <= 1'b1;
      regs_q  <= '0;
      idx_q   <= '0;
      step_q  <= HS_ID;
      upd_q   <= 1'b0;
      rdata_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      load_q <= 1'b0;
      upd_q  <= upd_d;
      vld_q  <= rd_en;
      if (upd_d)  regs_q  <= regs_d;
      if (wr_en)  idx_q   <= idx_d;
      if (rd_en || wr_en) step_q <= step_d;
      if (rd_en)  rdata_q <= rdata_d;
    end
  end

  assign rdata     = rdata_q;
  assign rdata_vld = vld_q;
  assign regs      = regs_q;
  assign upd       = upd_q;
  assign sel_idx   = idx_q;

endmodule

// File: rtl/sio_cfg_decode.sv
module sio_cfg_decode
  import sio_cfg_pkg::*;
#(
  parameter int IOW = IO_W,
  parameter int IQW = IRQ_W,
  parameter int NU  = NUM_UART
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cfg_regs_t         regs,
  input  logic              upd,
  output logic              cfg_changed,
  output logic              par_en,
  output logic [IOW-1:0]    par_base,
  output logic [IQW-1:0]    par_irq,
  output logic [NU-1:0]     uart_en,
  output logic [NU*IOW-1:0] uart_base,
  output logic [NU*IQW-1:0] uart_irq,
  output logic              fdc_en,
  output logic [IOW-1:0]    fdc_base,
  output logic [IQW-1:0]    fdc_irq,
  output logic              ide_en,
  output logic [IOW-1:0]    ide_base,
  output logic [IOW-1:0]    ide_alt_base,
  output logic [IQW-1:0]    ide_irq
);

  localparam logic [IOW-1:0] IDE_ALT_OFS = IOW'(16'h0206);

  function automatic logic [IOW-1:0] uart_map(input logic [1:0] code, input logic [1:0] row);
    logic [IOW-1:0] b;
    unique case ({code, row})
      4'b00_00, 4'b00_01, 4'b00_10, 4'b00_11: b = IOW'(16'h03F8);
      4'b01_00, 4'b01_01, 4'b01_10, 4'b01_11: b = IOW'(16'h02F8);
      4'b10_00: b = IOW'(16'h03E8);
      4'b10_01: b = IOW'(16'h0338);
      4'b10_10: b = IOW'(16'h02E8);
      4'b10_11: b = IOW'(16'h0220);
      4'b11_00: b = IOW'(16'h02E8);
      4'b11_01: b = IOW'(16'h0238);
      4'b11_10: b = IOW'(16'h02E0);
      default:  b = IOW'(16'h0228);
    endcase
    return b;
  endfunction

  logic [IOW-1:0] par_base_d;
  logic [IQW-1:0] par_irq_d;
  logic [IOW-1:0] fdc_base_d, ide_base_d;
  logic [NU*IOW-1:0] uart_base_d;
  logic [NU*IQW-1:0] uart_irq_d;

  always_comb begin
    unique case (regs.addr[1:0])
      2'd0: begin
        par_base_d = IOW'(16'h0378);
        par_irq_d  = regs.pwr[3] ? IQW'(7) : IQW'(5);
      end
      2'd1: begin
        par_base_d = IOW'(16'h03BC);
        par_irq_d  = IQW'(7);
      end
      2'd2: begin
        par_base_d = IOW'(16'h0278);
        par_irq_d  = IQW'(5);
      end
      default: begin
        par_base_d = '0;
        par_irq_d  = '0;
      end
    endcase
    fdc_base_d = regs.en[5] ? IOW'(16'h0370) : IOW'(16'h03F0);
    ide_base_d = regs.en[7] ? IOW'(16'h0170) : IOW'(16'h01F0);
  end

  for (genvar u = 0; u < NU; u++) begin : g_uart
    logic [1:0] code;
    assign code = regs.addr[2*u+3 -: 2];
    assign uart_base_d[u*IOW +: IOW] = uart_map(code, regs.addr[7:6]);
    assign uart_irq_d[u*IQW +: IQW]  = code[0] ? IQW'(3) : IQW'(4);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_changed  <= 1'b0;
      par_en       <= 1'b0;
      par_base     <= '0;
      par_irq      <= '0;
      uart_en      <= '0;
      uart_base    <= '0;
      uart_irq     <= '0;
      fdc_en       <= 1'b0;
      fdc_base     <= '0;
      fdc_irq      <= '0;
      ide_en       <= 1'b0;
      ide_base     <= '0;
      ide_alt_base <= '0;
      ide_irq      <= '0;
    end else begin
      cfg_changed <= upd;
      if (upd) begin
        par_en       <= regs.en[0];
        par_base     <= par_base_d;
        par_irq      <= par_irq_d;
        uart_en      <= regs.en[NU:1];
        uart_base    <= uart_base_d;
        uart_irq     <= uart_irq_d;
        fdc_en       <= regs.en[3];
        fdc_base     <= fdc_base_d;
        fdc_irq      <= IQW'(6);
        ide_en       <= regs.en[6];
        ide_base     <= ide_base_d;
        ide_alt_base <= ide_base_d + IDE_ALT_OFS;
        ide_irq      <= IQW'(14);
      end
    end
  end

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [STRAP_W-1:0]     strap,
  input  logic                   bus_a0,
  input  logic                   rd_en,
  input  logic                   wr_en,
  input  logic [REG_W-1:0]       wdata,
  output logic [REG_W-1:0]       rdata,
  output logic                   rdata_vld,
  output logic                   cfg_changed,
  output logic                   par_en,
  output logic [IO_W-1:0]        par_base,
  output logic [IRQ_W-1:0]       par_irq,
  output logic [NUM_UART-1:0]    uart_en,
  output logic [NUM_UART*IO_W-1:0]  uart_base,
  output logic [NUM_UART*IRQ_W-1:0] uart_irq,
  output logic                   fdc_en,
  output logic [IO_W-1:0]        fdc_base,
  output logic [IRQ_W-1:0]       fdc_irq,
  output logic                   ide_en,
  output logic [IO_W-1:0]        ide_base,
  output logic [IO_W-1:0]        ide_alt_base,
  output logic [IRQ_W-1:0]       ide_irq
);

  cfg_regs_t        regs;
  logic             upd;
  logic [REG_W-1:0] sel_idx;

  sio_cfg_bus u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap     (strap),
    .bus_a0    (bus_a0),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .wdata     (wdata),
    .rdata     (rdata),
    .rdata_vld (rdata_vld),
    .regs      (regs),
    .upd       (upd),
    .sel_idx   (sel_idx)
  );

  sio_cfg_decode u_dec (
    .clk          (clk),
    .rst_n        (rst_n),
    .regs         (regs),
    .upd          (upd),
    .cfg_changed  (cfg_changed),
    .par_en       (par_en),
    .par_base     (par_base),
    .par_irq      (par_irq),
    .uart_en      (uart_en),
    .uart_base    (uart_base),
    .uart_irq     (uart_irq),
    .fdc_en       (fdc_en),
    .fdc_base     (fdc_base),
    .fdc_irq      (fdc_irq),
    .ide_en       (ide_en),
    .ide_base     (ide_base),
    .ide_alt_base (ide_alt_base),
    .ide_irq      (ide_irq)
  );

endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_a0,
  input logic        rd_en,
  input logic        wr_en,
  input logic [7:0]  wdata,
  input logic [7:0]  rdata,
  input logic        rdata_vld,
  input logic        cfg_changed,
  input logic [15:0] par_base,
  input logic [31:0] uart_base,
  input logic [7:0]  uart_irq,
  input logic [15:0] ide_base,
  input logic [7:0]  sel_idx
);

  // R1
  rd_gives_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rdata_vld);

  // R3
  idx_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !bus_a0) |=> (sel_idx == $past(wdata)));

  // R4
  bad_idx_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bus_a0 && sel_idx >= 8'd3) |=> (rdata == 8'h00));

  // R6
  quiet_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_changed |-> ($stable(par_base) && $stable(uart_base) && $stable(ide_base)));

  // R8
  uart_irq_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_changed |-> ((uart_irq[3:0] == 4'd3 || uart_irq[3:0] == 4'd4) &&
                     (uart_irq[7:4] == 4'd3 || uart_irq[7:4] == 4'd4)));

endmodule

bind sio_cfg_port sio_cfg_port_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_a0      (bus_a0),
  .rd_en       (rd_en),
  .wr_en       (wr_en),
  .wdata       (wdata),
  .rdata       (rdata),
  .rdata_vld   (rdata_vld),
  .cfg_changed (cfg_changed),
  .par_base    (par_base),
  .uart_base   (uart_base),
  .uart_irq    (uart_irq),
  .ide_base    (ide_base),
  .sel_idx     (sel_idx)
);

// File: tb/tb_sio_cfg_port.sv
`timescale 1ns/1ps
module tb_sio_cfg_port;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  strap;
  logic        bus_a0, rd_en, wr_en;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic        rdata_vld, cfg_changed, par_en, fdc_en, ide_en;
  logic [15:0] par_base, fdc_base, ide_base, ide_alt_base;
  logic [3:0]  par_irq, fdc_irq, ide_irq;
  logic [1:0]  uart_en;
  logic [31:0] uart_base;
  logic [7:0]  uart_irq;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  sio_cfg_port dut (.*);

  int en_tab[32] = '{'h4F,'h4F,'h4F,'h4F,'h4F,'h4F,'h4B,'h4B,'h4B,'h4B,'h4B,'h4B,
                     'h0F,'h0F,'h0F,'h0F,'h49,'h49,'h49,'h49,'h07,'h07,'h07,'h07,
                     'h47,'h47,'h47,'h47,'h47,'h47,'h08,'h00};
  int ad_tab[32] = '{'h10,'h11,'h11,'h39,'h24,'h38,'h00,'h01,'h01,'h09,'h08,'h08,
                     'h10,'h11,'h39,'h24,'h00,'h01,'h01,'h00,'h10,'h11,'h39,'h24,
                     'h10,'h11,'h11,'h39,'h24,'h38,'h10,'h10};
  int par_b[4] = '{'h378, 'h3BC, 'h278, 0};
  int par_i[4] = '{5, 7, 5, 0};
  int u_hi[2][4] = '{'{'h3E8, 'h338, 'h2E8, 'h220}, '{'h2E8, 'h238, 'h2E0, 'h228}};

  // behavioural model
  int m_reg[3];
  int m_idx, m_step, m_rdata;
  bit m_load, m_upd, m_vld, m_chg, m_live;
  string m_rtag;
  int e_par_en, e_par_base, e_par_irq, e_fdc_en, e_fdc_base, e_fdc_irq;
  int e_ide_en, e_ide_base, e_ide_irq;
  int e_u_en[2], e_u_base[2], e_u_irq[2];

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_decode();
    int pc, c, row;
    pc = m_reg[1] & 3;
    e_par_en   = m_reg[0] & 1;
    e_par_base = par_b[pc];
    e_par_irq  = (pc == 0) ? (((m_reg[2] >> 3) & 1) ? 7 : 5) : par_i[pc];
    row = (m_reg[1] >> 6) & 3;
    for (int u = 0; u < 2; u++) begin
      c = (m_reg[1] >> (2 * u + 2)) & 3;
      e_u_en[u]   = (m_reg[0] >> (u + 1)) & 1;
      e_u_base[u] = (c == 0) ? 'h3F8 : (c == 1) ? 'h2F8 : u_hi[c - 2][row];
      e_u_irq[u]  = (c % 2 == 1) ? 3 : 4;
    end
    e_fdc_en   = (m_reg[0] >> 3) & 1;
    e_fdc_base = ((m_reg[0] >> 5) & 1) ? 'h370 : 'h3F0;
    e_fdc_irq  = 6;
    e_ide_en   = (m_reg[0] >> 6) & 1;
    e_ide_base = ((m_reg[0] >> 7) & 1) ? 'h170 : 'h1F0;
    e_ide_irq  = 14;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_idx = 0; m_step = 0; m_load = 1; m_upd = 0; m_vld = 0; m_chg = 0; m_live = 1;
      e_par_en = 0; e_par_base = 0; e_par_irq = 0; e_fdc_en = 0; e_fdc_base = 0;
      e_fdc_irq = 0; e_ide_en = 0; e_ide_base = 0; e_ide_irq = 0;
      for (int u = 0; u < 2; u++) begin e_u_en[u] = 0; e_u_base[u] = 0; e_u_irq[u] = 0; end
    end else begin
      bit nupd;
      nupd = 0;
      m_chg = m_upd;
      if (m_upd) model_decode();
      m_vld = rd_en;
      if (rd_en) begin
        if (!bus_a0) begin
          m_rtag = "R2";
          m_rdata = (m_step == 0) ? 'h88 : (m_step == 1) ? 0 : m_idx;
          if (m_step < 2) m_step++;
        end else begin
          m_rtag = "R4";
          m_rdata = (m_idx < 3) ? m_reg[m_idx] : 0;
        end
      end
      if (m_load) begin
        m_reg[0] = en_tab[strap];
        m_reg[1] = ad_tab[strap];
        m_reg[2] = (strap == 31) ? 2 : 0;
        m_load = 0;
        nupd = 1;
      end else if (wr_en && bus_a0 && m_idx < 3) begin
        m_reg[m_idx] = wdata;
        nupd = 1;
      end
      if (wr_en && !bus_a0) begin
        m_idx = wdata;
        m_step = 2;
      end
      m_upd = nupd;
    end
  end

  always @(negedge clk) begin
    if (rst_n && m_live) begin
      chk("R1", rdata_vld, m_vld);
      if (m_vld) chk(m_rtag, rdata, m_rdata);
      chk("R6", cfg_changed, m_chg);
      chk("R7", par_en, e_par_en);
      chk("R7", par_base, e_par_base);
      chk("R7", par_irq, e_par_irq);
      for (int u = 0; u < 2; u++) begin
        chk("R8", uart_en[u], e_u_en[u]);
        chk("R8", uart_base[u*16 +: 16], e_u_base[u]);
        chk("R8", uart_irq[u*4 +: 4], e_u_irq[u]);
      end
      chk("R9", fdc_en, e_fdc_en);
      chk("R9", fdc_base, e_fdc_base);
      chk("R9", fdc_irq, e_fdc_irq);
      chk("R10", ide_en, e_ide_en);
      chk("R10", ide_base, e_ide_base);
      chk("R10", ide_irq, e_ide_irq);
      chk("R10", ide_alt_base, (e_ide_base == 0) ? 0 : e_ide_base + 'h206);
    end
  end

  task automatic do_reset(input int s);
    @(negedge clk);
    rst_n = 1'b0;
    strap = 5'(s);
    repeat (2) @(negedge clk);
    chk("R5", rdata_vld, 0);
    chk("R5", cfg_changed, 0);
    chk("R5", par_en, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_wr(input bit a, input int d);
    bus_a0 = a; wr_en = 1'b1; wdata = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input bit a, input string req, input int exp);
    bus_a0 = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R1", rdata_vld, 1);
    chk(req, rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; strap = 5'd1; bus_a0 = 0; rd_en = 0; wr_en = 0; wdata = 0;
    m_live = 0;
    do_reset(1);
    // handshake then index echo, R2
    do_rd(0, "R2", 'h88);
    do_rd(0, "R2", 'h00);
    do_rd(0, "R2", 'h00);
    // preset strap 1, R5
    do_rd(1, "R5", 'h4F);
    do_wr(0, 1);
    do_rd(1, "R5", 'h11);
    do_rd(0, "R3", 1);
    do_wr(0, 2);
    do_rd(1, "R5", 'h00);
    // out-of-range index, R4
    do_wr(0, 'hC7);
    do_wr(1, 'h5A);
    do_rd(1, "R4", 'h00);
    do_rd(0, "R3", 'hC7);
    do_wr(0, 0);
    do_rd(1, "R4", 'h4F);
    // patterns through the three registers
    for (int p = 0; p < 24; p++) begin
      do_wr(0, 0); do_wr(1, (p * 37) ^ 'hA5);
      do_wr(0, 1); do_wr(1, (p * 53 + p / 4) & 'hFF);
      do_wr(0, 2); do_wr(1, (p % 2) ? 'h08 : 'h00);
      repeat (2) @(negedge clk);
      chk("R10", ide_alt_base, ide_base + 16'h0206);
      chk("R9", fdc_irq, 6);
    end
    // index write ends the handshake, R3
    do_reset(12);
    do_wr(0, 2);
    do_rd(0, "R3", 2);
    foreach (ad_tab[s]) begin
      if (s % 5 == 1 || s == 31 || s == 30) begin
        do_reset(s);
        do_rd(0, "R2", 'h88);
        do_rd(1, "R5", en_tab[s]);
        do_wr(0, 1);
        do_rd(1, "R5", ad_tab[s]);
        do_wr(0, 2);
        do_rd(1, "R5", (s == 31) ? 2 : 0);
      end
    end
    repeat (3) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule